// File: doc/BRIEF.md
# Stereo Ping-Pong Delay Line Controller

This block runs a circular stereo delay line held in an external asynchronous word-wide SRAM. Each accepted stereo sample is stored as two consecutive 16-bit words, left then right, at a write pointer that moves forward by two words per sample. In the same period two older words are fetched from the pointer minus a delay given in words. The fetched words are routed to the opposite output channels, so sound that goes in on one side comes back out on the other. When the delay is even and some feedback is added outside the block, echoes bounce from side to side.

Samples enter over a valid/ready handshake and leave over a valid/ready handshake. The rules for back-pressure are as follows. The block takes a new sample only while it is idle and no earlier result is waiting. A result stays on the outputs, unchanged, until the consumer raises `out_ready`. While `in_ready` is low, `in_valid` has no effect. After reset the block zeroes every SRAM address before it accepts its first sample, so stale memory contents never reach the outputs.

Top module: `pingpong_delay`

## Requirements
- R1: After reset, `out_valid` and `in_ready` are low and both output samples are zero. The block then writes zero to every address from 0 to 2^ADDR_W-1, one address per cycle, and raises `in_ready` only once that clear is complete.
- R2: With W the write pointer (0 after the clear), an accepted sample writes its left word at address W and its right word at W+1. W then advances by 2 modulo 2^ADDR_W.
- R3: `delay_words` is captured on the accepting edge as D. The two words for that period are read from addresses W-D and W-D+1, taken modulo 2^ADDR_W.
- R4: The SRAM accesses of a period take one cycle each, in this fixed order: read at W-D, write left, read at W-D+1, write right. With D=1, the second read therefore returns the left word just written.
- R5: The word read from W-D is presented on `out_right` and the word read from W-D+1 on `out_left`. With D=2, the left input of one period appears on the right output in the next period.
- R6: `sram_dq` is driven only in cycles with `sram_we_n` low. `sram_oe_n` is low only in read cycles, `sram_ce_n` is low in every access cycle, and `sram_we_n` and `sram_oe_n` are never low together.
- R7: `out_valid` rises on the fourth rising edge after the accepting edge. While `out_ready` is low, `out_valid`, `out_left` and `out_right` hold.
- R8: `in_ready` is high only when the sequencer is idle and no result is pending. `in_valid` presented while `in_ready` is low neither moves the pointer nor writes memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can take a sample |
| in_left | input | 16 | Left input sample |
| in_right | input | 16 | Right input sample |
| delay_words | input | ADDR_W | Delay in words, captured with the sample |
| out_valid | output | 1 | Delayed sample pair valid |
| out_ready | input | 1 | Consumer takes the output pair |
| out_left | output | 16 | Left output (fetched from the right slot) |
| out_right | output | 16 | Right output (fetched from the left slot) |
| sram_addr | output | ADDR_W | SRAM word address |
| sram_dq | inout | 16 | SRAM data bus |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |

## Verification
The SRAM model in the bench is filled with a nonzero pattern before reset. A clear that skipped any address would therefore leak that pattern into the memory check or into the early outputs. The bench checks delays of 0, 1, 2 and the largest value, and enough samples to wrap the pointer. A design that ordered the accesses differently, dropped the modulo wrap or left the channels uncrossed would return the wrong word for at least one of these cases. The bench also holds `out_ready` low with `in_valid` raised. A block that let that stimulus through would change its held output or move its pointer, and every address and data check that follows would go wrong.

// File: rtl/pp_pkg.sv
package pp_pkg;
  typedef enum logic [2:0] {
    ST_CLEAR,
    ST_IDLE,
    ST_RD_L,
    ST_WR_L,
    ST_RD_R,
    ST_WR_R
  } pp_state_e;
endpackage

// File: rtl/pp_seq.sv
module pp_seq
  import pp_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_fire,
  output pp_state_e         state,
  output logic [ADDR_W-1:0] clr_addr,
  output logic              period_done
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_CLEAR;
      clr_addr <= '0;
    end else begin
      case (state)
        ST_CLEAR: begin
          clr_addr <= clr_addr + ONE;
          if (clr_addr == LAST_ADDR) state <= ST_IDLE;
        end
        ST_IDLE:  if (in_fire) state <= ST_RD_L;
        ST_RD_L:  state <= ST_WR_L;
        ST_WR_L:  state <= ST_RD_R;
        ST_RD_R:  state <= ST_WR_R;
        ST_WR_R:  state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign period_done = (state == ST_WR_R);

  // R1: the clear walks every address before leaving
  a_r1_clear_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CLEAR && clr_addr != LAST_ADDR) |=> (state == ST_CLEAR));

  // R4: an accepted sample always starts with the left read
  a_r4_start_read: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> (state == ST_RD_L));

  // R4: the right read follows the left write
  a_r4_order: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WR_L) |=> (state == ST_RD_R));
endmodule

// File: rtl/pp_ptr.sv
module pp_ptr
  import pp_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_fire,
  input  logic [ADDR_W-1:0] delay_in,
  input  logic              period_done,
  input  pp_state_e         state,
  input  logic [ADDR_W-1:0] clr_addr,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};
  localparam logic [ADDR_W-1:0] TWO = {{(ADDR_W-2){1'b0}}, 2'b10};

  logic [ADDR_W-1:0] wr_ptr;
  logic [ADDR_W-1:0] delay_q;
  logic [ADDR_W-1:0] rd_base;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      delay_q <= '0;
    end else begin
      if (in_fire)     delay_q <= delay_in;
      if (period_done) wr_ptr  <= wr_ptr + TWO;
    end
  end

  assign rd_base = wr_ptr - delay_q;

  always_comb begin
    case (state)
      ST_CLEAR: addr = clr_addr;
      ST_RD_L:  addr = rd_base;
      ST_WR_L:  addr = wr_ptr;
      ST_RD_R:  addr = rd_base + ONE;
      ST_WR_R:  addr = wr_ptr + ONE;
      default:  addr = wr_ptr;
    endcase
  end

  // R3: the left read sits exactly D words behind the left write
  a_r3_read_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WR_L) |-> (($past(addr) + delay_q) == addr));

  // R2: the right word lands one address above the left word
  a_r2_pair_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WR_R) |-> (addr == $past(addr, 2) + ONE));
endmodule

// File: rtl/pp_out.sv
module pp_out
  import pp_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_fire,
  input  logic [DATA_W-1:0] in_left,
  input  logic [DATA_W-1:0] in_right,
  input  pp_state_e         state,
  input  logic [DATA_W-1:0] rd_word,
  input  logic              period_done,
  input  logic              out_ready,
  output logic [DATA_W-1:0] wr_word,
  output logic [DATA_W-1:0] out_left,
  output logic [DATA_W-1:0] out_right,
  output logic              out_valid
);
  logic [DATA_W-1:0] hold_l, hold_r;
  logic [DATA_W-1:0] chan_q [2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_l <= '0;
      hold_r <= '0;
    end else if (in_fire) begin
      hold_l <= in_left;
      hold_r <= in_right;
    end
  end

  always_comb begin
    case (state)
      ST_WR_L: wr_word = hold_l;
      ST_WR_R: wr_word = hold_r;
      default: wr_word = '0;
    endcase
  end

  // channel 0 = left output (takes the second read), 1 = right output
  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    localparam pp_state_e CAP_ST = (ch == 0) ? ST_RD_R : ST_RD_L;
    always_ff @(posedge clk) begin
      if (!rst_n)              chan_q[ch] <= '0;
      else if (state == CAP_ST) chan_q[ch] <= rd_word;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           out_valid <= 1'b0;
    else if (period_done) out_valid <= 1'b1;
    else if (out_ready)   out_valid <= 1'b0;
  end

  assign out_left  = chan_q[0];
  assign out_right = chan_q[1];

  // R7: a stalled result holds its data
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_left) && $stable(out_right)));
endmodule

// File: rtl/pingpong_delay.sv
module pingpong_delay
  import pp_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_left,
  input  logic [DATA_W-1:0] in_right,
  input  logic [ADDR_W-1:0] delay_words,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_left,
  output logic [DATA_W-1:0] out_right,
  output logic [ADDR_W-1:0] sram_addr,
  inout  wire  [DATA_W-1:0] sram_dq,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_oe_n
);
  pp_state_e         state;
  logic [ADDR_W-1:0] clr_addr;
  logic              period_done;
  logic              in_fire;
  logic [DATA_W-1:0] wr_word;
  logic              is_write, is_read;

  assign in_ready = (state == ST_IDLE) && !out_valid;
  assign in_fire  = in_valid && in_ready;

  pp_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .in_fire(in_fire),
    .state(state), .clr_addr(clr_addr), .period_done(period_done)
  );

  pp_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .in_fire(in_fire), .delay_in(delay_words),
    .period_done(period_done), .state(state), .clr_addr(clr_addr),
    .addr(sram_addr)
  );

  pp_out #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .in_fire(in_fire),
    .in_left(in_left), .in_right(in_right), .state(state),
    .rd_word(sram_dq), .period_done(period_done), .out_ready(out_ready),
    .wr_word(wr_word), .out_left(out_left), .out_right(out_right),
    .out_valid(out_valid)
  );

  assign is_write  = (state == ST_CLEAR) || (state == ST_WR_L) || (state == ST_WR_R);
  assign is_read   = (state == ST_RD_L) || (state == ST_RD_R);
  assign sram_we_n = !is_write;
  assign sram_oe_n = !is_read;
  assign sram_ce_n = !(is_write || is_read);
  assign sram_dq   = is_write ? wr_word : {DATA_W{1'bz}};

  // R6: read and write strobes never overlap
  a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(!sram_we_n && !sram_oe_n));

  // R6: any strobe needs the chip enabled
  a_r6_ce_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_we_n || !sram_oe_n) |-> !sram_ce_n);

  // R8: nothing is taken while a result is pending
  a_r8_no_accept_pending: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_fire);
endmodule

// File: tb/pingpong_delay_tb.sv
module pingpong_delay_tb;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int N  = 1 << AW;

  logic clk = 0;
  logic rst_n = 0;
  logic in_valid = 0;
  logic in_ready;
  logic [DW-1:0] in_left = 0, in_right = 0;
  logic [AW-1:0] delay_words = 0;
  logic out_valid;
  logic out_ready = 1;
  logic [DW-1:0] out_left, out_right;
  logic [AW-1:0] sram_addr;
  wire  [DW-1:0] sram_dq;
  logic sram_ce_n, sram_we_n, sram_oe_n;

  int checks = 0;
  int fails = 0;
  int overlap_err = 0;

  logic [DW-1:0] mem [N];
  logic [DW-1:0] ref_mem [N];
  logic [AW-1:0] wr_ref = 0;

  always #4 clk = ~clk;

  pingpong_delay #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_left(in_left), .in_right(in_right), .delay_words(delay_words),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_left(out_left), .out_right(out_right),
    .sram_addr(sram_addr), .sram_dq(sram_dq),
    .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n)
  );

  assign sram_dq = (!sram_ce_n && !sram_oe_n && sram_we_n) ? mem[sram_addr] : {DW{1'bz}};

  initial begin
    for (int i = 0; i < N; i++) begin
      mem[i] = 16'hA5A5;
      ref_mem[i] = 16'h0000;
    end
  end

  always @(posedge clk) begin
    if (!sram_ce_n && !sram_we_n) mem[sram_addr] <= sram_dq;
  end

  always @(negedge clk) begin
    if (rst_n && !sram_we_n && !sram_oe_n) overlap_err++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [DW-1:0] l, input logic [DW-1:0] r,
                      input logic [AW-1:0] d, input int hold);
    logic [AW-1:0] rd0, rd1, wr1;
    logic [DW-1:0] exp_r, exp_l, ol, orr;
    rd0 = wr_ref - d;
    rd1 = rd0 + 1'b1;
    wr1 = wr_ref + 1'b1;
    exp_r = ref_mem[rd0];
    ref_mem[wr_ref] = l;
    exp_l = ref_mem[rd1];
    ref_mem[wr1] = r;

    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_left = l; in_right = r; delay_words = d;
    out_ready = (hold == 0);
    @(negedge clk);  // first cycle after accepting edge
    in_valid = 0; delay_words = ~d;
    chk(sram_addr == rd0 && !sram_oe_n && sram_we_n && !sram_ce_n, "R3",
        "left read address", sram_addr, rd0);
    chk(out_valid == 0, "R7", "valid early", out_valid, 0);
    @(negedge clk);
    chk(sram_addr == wr_ref && !sram_we_n && sram_oe_n, "R2",
        "left write address", sram_addr, wr_ref);
    chk(sram_dq == l, "R6", "left write data", sram_dq, l);
    @(negedge clk);
    chk(sram_addr == rd1 && !sram_oe_n && sram_we_n, "R4",
        "right read address", sram_addr, rd1);
    @(negedge clk);
    chk(sram_addr == wr1 && !sram_we_n && sram_oe_n, "R2",
        "right write address", sram_addr, wr1);
    chk(sram_dq == r, "R6", "right write data", sram_dq, r);
    chk(out_valid == 0, "R7", "valid before 4th edge", out_valid, 0);
    @(negedge clk);
    chk(out_valid == 1, "R7", "valid on 4th edge", out_valid, 1);
    chk(out_right == exp_r, "R5", "right output", out_right, exp_r);
    chk(out_left == exp_l, "R5", "left output", out_left, exp_l);
    ol = out_left; orr = out_right;
    if (hold > 0) begin
      for (int h = 0; h < hold; h++) begin
        in_valid = 1; in_left = ~l; in_right = ~r; delay_words = d + 3'd5;
        @(negedge clk);
        chk(out_valid == 1 && out_left == ol && out_right == orr, "R7",
            "held output", out_left, ol);
        chk(in_ready == 0 && sram_ce_n, "R8", "stalled input", in_ready, 0);
      end
      in_valid = 0;
      out_ready = 1;
      @(negedge clk);
    end else begin
      @(negedge clk);
    end
    chk(out_valid == 0, "R7", "consumed", out_valid, 0);
    wr_ref = wr_ref + 2'd2;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    bit all_zero;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && in_ready == 0, "R1", "reset handshake", out_valid, 0);
    chk(out_left == 0 && out_right == 0, "R1", "reset outputs", out_left, 0);
    rst_n = 1;
    @(negedge clk);
    chk(in_ready == 0 && !sram_we_n, "R1", "clearing", in_ready, 0);
    while (!in_ready) @(negedge clk);
    all_zero = 1;
    for (int i = 0; i < N; i++) if (mem[i] != 0) all_zero = 0;
    chk(all_zero, "R1", "memory cleared", all_zero, 1);

    // R1: cleared memory comes back as zero
    send(16'h1111, 16'h2222, 8'd40, 0);
    send(16'h3333, 16'h4444, 8'd40, 0);
    // R5: ping-pong with D=2
    send(16'h1234, 16'hABCD, 8'd2, 0);
    // R4: D=1 returns the left word just written on the left output
    send(16'h5A5A, 16'hC3C3, 8'd1, 0);
    // R3: D=0 fetches the oldest slot
    send(16'h0F0F, 16'hF0F0, 8'd0, 0);
    // R3: largest delay
    send(16'h7777, 16'h8888, 8'(N - 1), 0);
    // R8: back-pressure with junk input
    send(16'h9999, 16'hAAAA, 8'd2, 3);
    send(16'hBBBB, 16'hCCCC, 8'd2, 0);

    for (int t = 0; t < 150; t++) begin
      logic [AW-1:0] d;
      int hold;
      d = 8'($urandom_range(0, N - 1));
      if (t % 5 == 0) d = 8'd2 * 8'($urandom_range(0, 20));
      hold = ($urandom_range(0, 7) == 0) ? int'($urandom_range(1, 3)) : 0;
      send(16'($urandom), 16'($urandom), d, hold);
    end

    chk(overlap_err == 0, "R6", "strobe overlap count", overlap_err, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule